// File: doc/BRIEF.md
# Single-Step Trace Trap Controller

This block sequences the single-step trace trap inside a small processor's exception unit. It holds two status bits. The enable bit (T) is under software control. The pending bit (P) is armed from T each time a real instruction begins, and it is consumed when that instruction ends. The block watches the instruction start and end strobes, other trap and interrupt requests, returns from service procedures, and privileged writes to the status bits. From these it decides whether a trace trap is raised, when it is raised, and which return address goes with it.

The trace trap gives way to any other exception. When a trap or interrupt arrives during a traced instruction, or at its end, that service is granted first. The trace trap is held as an owed request and is raised only when the service procedure returns. Some cases need special handling:

- An instruction start that is really the entry of an undefined-instruction trap does not arm P.
- A privileged write that clears P or T before the end of the instruction cancels the trap.
- A wait instruction owes its trap until an interrupt has been serviced.
- A multi-step looping instruction, marked by opcode byte 0x0E, can be suspended between steps by an interrupt. In that case it reports its own address, so that the next single step resumes the same instruction.

Top module: `ttc_trace_ctrl`

## Requirements
- R1: On an `insn_start` pulse with `insn_undef` low, P takes the value T held before that edge. P is visible on `stat_p` one cycle later.
- R2: An `insn_end` pulse while P is 1 and no trap or interrupt is outstanding drives `trc_fire` high for exactly one cycle on the next cycle, with `trc_ret_addr` equal to `next_pc`. P then reads 0.
- R3: An `insn_end` pulse while P is 0 raises no trace trap.
- R4: If `exc_req` or `irq_req` was high at any point since the last instruction start, up to and including the `insn_end` cycle, then `svc_grant` pulses on the next cycle and the trace trap is not raised. If P was 1 at that end, `trc_fire` pulses the cycle after the next `svc_return` pulse, with the address saved at the end.
- R5: An `insn_start` pulse with `insn_undef` high leaves P, T and the captured instruction context unchanged.
- R6: `psr_clr_we` clears T where `psr_clr_mask[0]` is 1 and clears P where `psr_clr_mask[1]` is 1. `psr_ld_we` loads `psr_ld_val[1]` into P and `psr_ld_val[0]` into T. A load takes priority over a clear in the same cycle. A P cleared before `insn_end` means no trace trap for that instruction.
- R7: For an instruction started with `insn_wait` high, an end with P set never fires at once. The trap is owed, with address `next_pc`, until the next `svc_return`.
- R8: When a deferred trap comes from an end with `insn_susp` high, and the instruction's opcode byte at start was 0x0E, the reported address is the `insn_pc` captured at start. For any other opcode it is `next_pc`.
- R9: At most one trace trap is raised between two instruction starts, and `trc_fire` never stays high for two consecutive cycles.
- R10: A synchronous active-high `rst` clears T, P, the owed request, `trc_fire`, `trc_ret_addr` and `svc_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_start | input | 1 | Instruction begins (one-cycle pulse) |
| insn_undef | input | 1 | Qualifies insn_start as undefined-instruction trap entry |
| insn_pc | input | AW | Address of the instruction starting |
| insn_opc | input | 8 | First opcode byte of the instruction starting |
| insn_wait | input | 1 | Instruction starting is a wait |
| insn_end | input | 1 | Instruction ends (one-cycle pulse) |
| insn_susp | input | 1 | Qualifies insn_end as a suspension between loop steps |
| next_pc | input | AW | Address of the following instruction, valid with insn_end |
| exc_req | input | 1 | Another trap is requested |
| irq_req | input | 1 | An interrupt is requested |
| svc_return | input | 1 | A service procedure returns (one-cycle pulse) |
| psr_clr_we | input | 1 | Privileged bit-clear write strobe |
| psr_clr_mask | input | 2 | Bits to clear: [1] P, [0] T |
| psr_ld_we | input | 1 | Privileged status load strobe |
| psr_ld_val | input | 2 | Value to load: [1] P, [0] T |
| trc_fire | output | 1 | Trace trap request, one-cycle pulse |
| trc_ret_addr | output | AW | Return address of the last trace trap |
| svc_grant | output | 1 | Other trap or interrupt service granted, one-cycle pulse |
| stat_t | output | 1 | Trace enable bit |
| stat_p | output | 1 | Trace pending bit |

## Verification
The assertions assume a well-formed strobe stream. Starts and ends alternate. `insn_start`, `insn_end` and `svc_return` never share a cycle, and status writes never coincide with an instruction end. A `svc_return` arrives only after a grant. The stimulus drives each strobe as a single-cycle pulse one time unit after a rising edge, spaced by idle cycles. Each scenario starts from a status load and runs one instruction or one service round trip. The bench's behavioural model is checked on every falling edge.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

    // Trace status pair: bit 1 is pending, bit 0 is enable
    typedef struct packed {
        logic pend;
        logic ena;
    } trc_stat_t;

    // Context captured at the start of an instruction
    typedef struct packed {
        logic loop_op;
        logic wait_op;
        logic exc_seen;
    } ctx_flags_t;

    typedef enum logic {
        OWE_NONE = 1'b0,
        OWE_HELD = 1'b1
    } owe_state_t;

    localparam logic [7:0] LOOP_OPCODE_DEFAULT = 8'h0E;

    function automatic trc_stat_t stat_clear(input trc_stat_t cur,
                                             input logic [1:0] mask);
        trc_stat_t r;
        r.pend = cur.pend & ~mask[1];
        r.ena  = cur.ena  & ~mask[0];
        return r;
    endfunction

    function automatic logic opc_is_loop(input logic [7:0] opc,
                                         input logic [7:0] code);
        return opc == code;
    endfunction

endpackage

// File: rtl/ttc_status.sv
module ttc_status
    import ttc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,        // real instruction start
    input  logic      consume,    // instruction end
    input  logic      clr_we,
    input  logic [1:0] clr_mask,
    input  logic      ld_we,
    input  logic [1:0] ld_val,
    output trc_stat_t stat
);

    trc_stat_t stat_nxt;

    always_comb begin
        stat_nxt = stat;
        if (arm)
            stat_nxt.pend = stat.ena;
        if (consume)
            stat_nxt.pend = 1'b0;
        if (ld_we)
            stat_nxt = trc_stat_t'(ld_val);
        else if (clr_we)
            stat_nxt = stat_clear(stat_nxt, clr_mask);
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat <= '0;
        else
            stat <= stat_nxt;
    end

    // R1
    arm_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && !ld_we && !clr_we) |=> (stat.pend == $past(stat.ena)));

    // R6
    clr_ena_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !ld_we && clr_mask[0]) |=> !stat.ena);

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld_we |=> (stat == $past(ld_val)));

endmodule

// File: rtl/ttc_capture.sv
module ttc_capture
    import ttc_pkg::*;
#(
    parameter int         AW       = 32,
    parameter logic [7:0] LOOP_OPC = LOOP_OPCODE_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          insn_end,
    input  logic [AW-1:0] insn_pc,
    input  logic [7:0]    insn_opc,
    input  logic          insn_wait,
    input  logic          req_now,
    output ctx_flags_t    ctx,
    output logic [AW-1:0] cur_pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx    <= '0;
            cur_pc <= '0;
        end else if (arm) begin
            cur_pc       <= insn_pc;
            ctx.loop_op  <= opc_is_loop(insn_opc, LOOP_OPC);
            ctx.wait_op  <= insn_wait;
            ctx.exc_seen <= req_now;
        end else if (insn_end) begin
            ctx.exc_seen <= 1'b0;
        end else if (req_now) begin
            ctx.exc_seen <= 1'b1;
        end
    end

    // R4
    seen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (req_now && !insn_end) |=> ctx.exc_seen);

endmodule

// File: rtl/ttc_arbiter.sv
module ttc_arbiter
    import ttc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          insn_end,
    input  logic          insn_susp,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] cur_pc,
    input  ctx_flags_t    ctx,
    input  logic          pend,
    input  logic          req_now,
    input  logic          svc_return,
    output logic          trc_fire,
    output logic [AW-1:0] trc_addr,
    output logic          svc_grant
);

    owe_state_t    owe_q;
    logic [AW-1:0] owe_addr;
    logic          service_first;
    logic          resume_self;
    logic [AW-1:0] defer_addr;

    assign service_first = ctx.exc_seen | req_now;
    assign resume_self   = insn_susp & ctx.loop_op;
    assign defer_addr    = resume_self ? cur_pc : next_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            owe_q     <= OWE_NONE;
            owe_addr  <= '0;
            trc_fire  <= 1'b0;
            trc_addr  <= '0;
            svc_grant <= 1'b0;
        end else begin
            trc_fire  <= 1'b0;
            svc_grant <= insn_end & service_first;
            if (insn_end && pend) begin
                if (service_first || ctx.wait_op) begin
                    owe_q    <= OWE_HELD;
                    owe_addr <= defer_addr;
                end else begin
                    trc_fire <= 1'b1;
                    trc_addr <= next_pc;
                end
            end else if (svc_return && owe_q == OWE_HELD) begin
                owe_q    <= OWE_NONE;
                trc_fire <= 1'b1;
                trc_addr <= owe_addr;
            end
        end
    end

    // R2
    fire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trc_fire |=> !trc_fire);

    // R3
    no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_end && !pend) |=> !trc_fire);

    // R4
    grant_first_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_end && pend && service_first) |=> (svc_grant && !trc_fire));

    // R8
    loop_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_end && pend && insn_susp && ctx.loop_op)
            |=> (owe_q == OWE_HELD && owe_addr == $past(cur_pc)));

endmodule

// File: rtl/ttc_trace_ctrl.sv
module ttc_trace_ctrl
    import ttc_pkg::*;
#(
    parameter int         AW       = 32,
    parameter logic [7:0] LOOP_OPC = LOOP_OPCODE_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          insn_start,
    input  logic          insn_undef,
    input  logic [AW-1:0] insn_pc,
    input  logic [7:0]    insn_opc,
    input  logic          insn_wait,
    input  logic          insn_end,
    input  logic          insn_susp,
    input  logic [AW-1:0] next_pc,
    input  logic          exc_req,
    input  logic          irq_req,
    input  logic          svc_return,
    input  logic          psr_clr_we,
    input  logic [1:0]    psr_clr_mask,
    input  logic          psr_ld_we,
    input  logic [1:0]    psr_ld_val,
    output logic          trc_fire,
    output logic [AW-1:0] trc_ret_addr,
    output logic          svc_grant,
    output logic          stat_t,
    output logic          stat_p
);

    trc_stat_t     stat;
    ctx_flags_t    ctx;
    logic [AW-1:0] cur_pc;
    logic          arm;
    logic          req_now;

    assign arm     = insn_start & ~insn_undef;
    assign req_now = exc_req | irq_req;

    ttc_status u_status (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .consume  (insn_end),
        .clr_we   (psr_clr_we),
        .clr_mask (psr_clr_mask),
        .ld_we    (psr_ld_we),
        .ld_val   (psr_ld_val),
        .stat     (stat)
    );

    ttc_capture #(.AW(AW), .LOOP_OPC(LOOP_OPC)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .insn_end  (insn_end),
        .insn_pc   (insn_pc),
        .insn_opc  (insn_opc),
        .insn_wait (insn_wait),
        .req_now   (req_now),
        .ctx       (ctx),
        .cur_pc    (cur_pc)
    );

    ttc_arbiter #(.AW(AW)) u_arbiter (
        .clk        (clk),
        .rst        (rst),
        .insn_end   (insn_end),
        .insn_susp  (insn_susp),
        .next_pc    (next_pc),
        .cur_pc     (cur_pc),
        .ctx        (ctx),
        .pend       (stat.pend),
        .req_now    (req_now),
        .svc_return (svc_return),
        .trc_fire   (trc_fire),
        .trc_addr   (trc_ret_addr),
        .svc_grant  (svc_grant)
    );

    assign stat_t = stat.ena;
    assign stat_p = stat.pend;

    // Tracks whether a trap was already raised since the last real start
    logic fired_in_insn;
    always_ff @(posedge clk) begin
        if (rst)
            fired_in_insn <= 1'b0;
        else if (arm)
            fired_in_insn <= 1'b0;
        else if (trc_fire)
            fired_in_insn <= 1'b1;
    end

    // R9
    one_per_insn_chk: assert property (@(posedge clk) disable iff (rst)
        trc_fire |-> !fired_in_insn);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!trc_fire && !svc_grant && !stat_t && !stat_p
                 && trc_ret_addr == '0));

endmodule

// File: tb/test_ttc_trace_ctrl.sv
module test_ttc_trace_ctrl;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          insn_start, insn_undef, insn_wait, insn_end, insn_susp;
    logic [AW-1:0] insn_pc, next_pc;
    logic [7:0]    insn_opc;
    logic          exc_req, irq_req, svc_return;
    logic          psr_clr_we, psr_ld_we;
    logic [1:0]    psr_clr_mask, psr_ld_val;
    logic          trc_fire, svc_grant, stat_t, stat_p;
    logic [AW-1:0] trc_ret_addr;

    always #10 clk = ~clk;

    ttc_trace_ctrl #(.AW(AW)) i_ttc_trace_ctrl (
        .clk(clk), .rst(rst),
        .insn_start(insn_start), .insn_undef(insn_undef), .insn_pc(insn_pc),
        .insn_opc(insn_opc), .insn_wait(insn_wait), .insn_end(insn_end),
        .insn_susp(insn_susp), .next_pc(next_pc), .exc_req(exc_req),
        .irq_req(irq_req), .svc_return(svc_return), .psr_clr_we(psr_clr_we),
        .psr_clr_mask(psr_clr_mask), .psr_ld_we(psr_ld_we),
        .psr_ld_val(psr_ld_val), .trc_fire(trc_fire),
        .trc_ret_addr(trc_ret_addr), .svc_grant(svc_grant),
        .stat_t(stat_t), .stat_p(stat_p)
    );

    int    checks = 0;
    int    failures = 0;
    string phase = "R10";
    bit    done = 0;

    // Behavioural reference state
    bit          m_t, m_p, m_fire, m_grant, m_owed, m_loop, m_wait, m_seen;
    logic [AW-1:0] m_addr, m_owed_addr, m_pc;

    always @(posedge clk) begin
        bit any_req, real_start, t0, p0;
        if (rst) begin
            m_t = 0; m_p = 0; m_fire = 0; m_grant = 0; m_owed = 0;
            m_loop = 0; m_wait = 0; m_seen = 0;
            m_addr = '0; m_owed_addr = '0; m_pc = '0;
        end else begin
            any_req    = m_seen || exc_req || irq_req;
            real_start = insn_start && !insn_undef;
            t0 = m_t; p0 = m_p;
            m_fire  = 0;
            m_grant = insn_end && any_req;
            if (insn_end && p0) begin
                if (any_req || m_wait) begin
                    m_owed = 1;
                    m_owed_addr = (insn_susp && m_loop) ? m_pc : next_pc;
                end else begin
                    m_fire = 1; m_addr = next_pc;
                end
            end else if (svc_return && m_owed) begin
                m_owed = 0; m_fire = 1; m_addr = m_owed_addr;
            end
            if (real_start) m_p = t0;
            if (insn_end) m_p = 0;
            if (psr_ld_we) begin
                m_p = psr_ld_val[1]; m_t = psr_ld_val[0];
            end else if (psr_clr_we) begin
                if (psr_clr_mask[1]) m_p = 0;
                if (psr_clr_mask[0]) m_t = 0;
            end
            if (real_start) begin
                m_pc = insn_pc; m_loop = (insn_opc == 8'h0E);
                m_wait = insn_wait; m_seen = exc_req || irq_req;
            end else if (insn_end) m_seen = 0;
            else if (exc_req || irq_req) m_seen = 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every cycle on the falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk(phase, "trc_fire",  {31'b0, trc_fire},  {31'b0, m_fire});
            chk(phase, "svc_grant", {31'b0, svc_grant}, {31'b0, m_grant});
            chk(phase, "stat_t",    {31'b0, stat_t},    {31'b0, m_t});
            chk(phase, "stat_p",    {31'b0, stat_p},    {31'b0, m_p});
            chk(phase, "ret_addr",  trc_ret_addr,       m_addr);
        end
    end

    task automatic idle_all();
        insn_start = 0; insn_undef = 0; insn_wait = 0; insn_end = 0;
        insn_susp = 0; exc_req = 0; irq_req = 0; svc_return = 0;
        psr_clr_we = 0; psr_ld_we = 0; psr_clr_mask = 0; psr_ld_val = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle_all();
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load_stat(input logic [1:0] v);
        psr_ld_we = 1; psr_ld_val = v; step();
    endtask

    task automatic start_insn(input logic [AW-1:0] pc, input logic [7:0] opc,
                              input bit undef, input bit wt);
        insn_start = 1; insn_pc = pc; insn_opc = opc;
        insn_undef = undef; insn_wait = wt; step();
    endtask

    task automatic end_insn(input logic [AW-1:0] npc, input bit susp,
                            input bit irq);
        insn_end = 1; next_pc = npc; insn_susp = susp; irq_req = irq; step();
    endtask

    // Explicit point check on the falling edge after the last step
    task automatic at_neg(input string req, input string what,
                          input logic [AW-1:0] act, input logic [AW-1:0] exp);
        @(negedge clk); #1;
        chk(req, what, act, exp);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired in phase %s actual=hung expected=done", phase);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_all(); insn_pc = '0; next_pc = '0; insn_opc = '0;
        rst = 1;
        @(posedge clk); #1; @(posedge clk); #1;
        rst = 0;
        phase = "R10";
        at_neg("R10", "stat_p after reset", {31'b0, stat_p}, '0);

        // R1, R2: plain traced instruction
        phase = "R1";
        load_stat(2'b01);
        start_insn(32'h100, 8'h12, 0, 0);
        at_neg("R1", "P armed from T", {31'b0, stat_p}, 32'd1);
        phase = "R2";
        wait_cycles(2);
        end_insn(32'h104, 0, 0);
        at_neg("R2", "trap pulse", {31'b0, trc_fire}, 32'd1);
        at_neg("R2", "return addr", trc_ret_addr, 32'h104);
        step();
        at_neg("R2", "pulse ended", {31'b0, trc_fire}, 32'd0);

        // R9: a second end without a start raises nothing
        phase = "R9";
        end_insn(32'h108, 0, 0);
        at_neg("R9", "no second trap", {31'b0, trc_fire}, 32'd0);

        // R3: tracing off
        phase = "R3";
        load_stat(2'b00);
        start_insn(32'h200, 8'h12, 0, 0);
        end_insn(32'h204, 0, 0);
        at_neg("R3", "no trap when P clear", {31'b0, trc_fire}, 32'd0);

        // R4: interrupt during instruction
        phase = "R4";
        load_stat(2'b01);
        start_insn(32'h300, 8'h12, 0, 0);
        irq_req = 1; step();
        end_insn(32'h304, 0, 0);
        at_neg("R4", "service granted", {31'b0, svc_grant}, 32'd1);
        at_neg("R4", "trap held", {31'b0, trc_fire}, 32'd0);
        wait_cycles(3);
        svc_return = 1; step();
        at_neg("R4", "trap after return", {31'b0, trc_fire}, 32'd1);
        at_neg("R4", "deferred addr", trc_ret_addr, 32'h304);
        // R4: coincident at the end cycle only
        start_insn(32'h310, 8'h12, 0, 0);
        exc_req = 1; end_insn(32'h314, 0, 0);
        at_neg("R4", "coincident grant", {31'b0, svc_grant}, 32'd1);
        step();
        svc_return = 1; step();
        at_neg("R4", "coincident addr", trc_ret_addr, 32'h314);

        // R5: undefined-instruction entry does not arm P
        phase = "R5";
        load_stat(2'b01);
        start_insn(32'h400, 8'h12, 1, 0);
        at_neg("R5", "P unchanged", {31'b0, stat_p}, 32'd0);
        end_insn(32'h404, 0, 0);
        at_neg("R5", "no trap", {31'b0, trc_fire}, 32'd0);

        // R6: clear port cancels the trap, load beats clear
        phase = "R6";
        start_insn(32'h500, 8'h12, 0, 0);
        psr_clr_we = 1; psr_clr_mask = 2'b11; step();
        at_neg("R6", "T cleared", {31'b0, stat_t}, 32'd0);
        end_insn(32'h504, 0, 0);
        at_neg("R6", "no trap after clear", {31'b0, trc_fire}, 32'd0);
        psr_clr_we = 1; psr_clr_mask = 2'b11;
        psr_ld_we = 1; psr_ld_val = 2'b11; step();
        at_neg("R6", "load wins P", {31'b0, stat_p}, 32'd1);
        psr_clr_we = 1; psr_clr_mask = 2'b01; step();
        at_neg("R6", "P kept by T-only clear", {31'b0, stat_p}, 32'd1);

        // R7: wait instruction, with and without interrupt at end
        phase = "R7";
        load_stat(2'b01);
        start_insn(32'h600, 8'h12, 0, 1);
        end_insn(32'h602, 0, 1);
        at_neg("R7", "no immediate trap", {31'b0, trc_fire}, 32'd0);
        svc_return = 1; step();
        at_neg("R7", "trap after service", trc_ret_addr, 32'h602);
        start_insn(32'h610, 8'h12, 0, 1);
        end_insn(32'h612, 0, 0);
        at_neg("R7", "wait still held", {31'b0, trc_fire}, 32'd0);
        wait_cycles(2);
        svc_return = 1; step();
        at_neg("R7", "held wait trap", {31'b0, trc_fire}, 32'd1);

        // R8: suspended looping instruction reports its own address
        phase = "R8";
        start_insn(32'h700, 8'h0E, 0, 0);
        end_insn(32'h706, 1, 1);
        at_neg("R8", "loop grant", {31'b0, svc_grant}, 32'd1);
        svc_return = 1; step();
        at_neg("R8", "loop return addr", trc_ret_addr, 32'h700);
        start_insn(32'h800, 8'h12, 0, 0);
        end_insn(32'h806, 1, 1);
        svc_return = 1; step();
        at_neg("R8", "non-loop addr", trc_ret_addr, 32'h806);

        // R10: reset in the middle of a held trap
        phase = "R10";
        start_insn(32'h900, 8'h12, 0, 0);
        end_insn(32'h904, 0, 1);
        rst = 1; step(); rst = 0;
        at_neg("R10", "T after reset", {31'b0, stat_t}, 32'd0);
        svc_return = 1; step();
        at_neg("R10", "owed cleared", {31'b0, trc_fire}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule